// File: doc/BRIEF.md
# Ownership-Flagged Mailbox Window

This block is a small shared-memory mailbox that sits between two agents: a requester that composes a message and a responder that acts on it. The window holds eight 32-bit words. The requester fills the payload words through its own write/read port and then writes the last word, which carries the control header. That write hands the window to the responder. The handover is recorded in the top bit of that last word, which the hardware sets itself.

The responder has a second port of its own. It reads the payload and then writes a reply header into the last word. That write clears the ownership bit and gives the window back to the requester. Each handover produces a one-cycle pulse towards the side that now owns the window. Requester writes made while the responder owns the window are dropped and recorded in a sticky error flag. While the requester function is held in reset, every requester read returns all ones, so software can tell a dead channel from a live one.

The header word is laid out as follows:
- bits [2:0]: message type
- bits [5:3]: version
- bit 7: direction (0 request, 1 reply)
- bits [15:8]: status (0 success, nonzero failure)
- bit 24: reset-function flag
- bit 31: owner

The remaining bits are reserved. The block stores every header bit as written, except the owner bit.

Top module: `mbox_aperture`

## Requirements
- R1: After reset, every word reads 0, the owner bit (bit 31 of word 7) is 0, and both handover pulses and the error flag are 0.
- R2: While the owner bit is 0 and the requester is not held in reset, a requester write to words 0 to 6 stores the data as written. A read returns, in the cycle after the read strobe, the value the word held at the strobe edge.
- R3: A requester write accepted into word 7 stores bits [30:0] as written and sets bit 31 to 1, whatever the written bit 31 was.
- R4: `hand_to_rs` is high for exactly the one cycle after each accepted requester write to word 7, and at no other time.
- R5: A requester write, with the requester not held in reset, made while the owner bit is 1 changes no word. It sets `rq_wr_err`, which stays 1 until reset.
- R6: The responder reads any word with the same one-cycle latency as the requester. While the owner bit is 1, a responder write stores its data. A responder write to word 7 stores bits [30:0] and clears bit 31, whatever the written bit 31 was.
- R7: `hand_to_rq` is high for exactly the one cycle after each accepted responder write to word 7, and at no other time.
- R8: A responder write while the owner bit is 0 changes no word, raises no pulse and leaves the error flag unchanged.
- R9: While `rq_held_rst` is 1, every requester read returns 32'hFFFFFFFF. Requester writes are then ignored and do not set the error flag. Responder reads still return the stored words.
- R10: The header fields written by the responder reach the requester bit-exact, apart from bit 31 reading 0. These fields are the type [2:0], direction bit 7, status [15:8] and reset-function flag bit 24.
- R11: When both sides write in the same cycle, only the side that the current owner bit admits takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_held_rst | input | 1 | Requester function held in reset |
| rq_wr | input | 1 | Requester write strobe |
| rq_rd | input | 1 | Requester read strobe |
| rq_idx | input | 3 | Requester word index |
| rq_wdata | input | 32 | Requester write data |
| rq_rdata | output | 32 | Requester read data, valid the cycle after `rq_rd` |
| rs_wr | input | 1 | Responder write strobe |
| rs_rd | input | 1 | Responder read strobe |
| rs_idx | input | 3 | Responder word index |
| rs_wdata | input | 32 | Responder write data |
| rs_rdata | output | 32 | Responder read data, valid the cycle after `rs_rd` |
| hand_to_rs | output | 1 | One-cycle pulse: the window passed to the responder |
| hand_to_rq | output | 1 | One-cycle pulse: the window passed back to the requester |
| rq_wr_err | output | 1 | Sticky flag: a requester write was dropped while the responder owned the window |

## Verification
The bench writes word 7 with bit 31 both clear and set, and checks that the stored owner bit follows the writer and not the data. A design that copied the data bit would leave the window unowned, or stuck with the responder. It writes from the requester while the responder owns the window and reads the target word back. A design missing the gate would overwrite the payload, or would fail to latch the error. It holds the requester in reset and checks that reads return all ones and that writes neither land nor flag an error. It also checks that responder reads keep seeing real data. Finally, it drives both ports into word 7 in the same cycle, once in each ownership state. A wrong arbitration would either let the refused side win or pulse both handover outputs at once.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DW = 32;

    // Control word held in the last slot of the window.
    typedef struct packed {
        logic       owner;      // 31: 1 = responder holds the window
        logic [5:0] rsvd_hi;    // 30:25
        logic       fn_reset;   // 24
        logic [7:0] rsvd_mid;   // 23:16
        logic [7:0] status;     // 15:8
        logic       dir;        // 7: 0 request, 1 reply
        logic       rsvd_lo;    // 6
        logic [2:0] ver;        // 5:3
        logic [2:0] mtype;      // 2:0
    } ctl_word_t;

    function automatic logic [DW-1:0] with_owner(input logic [DW-1:0] w, input logic o);
        ctl_word_t c;
        c = ctl_word_t'(w);
        c.owner = o;
        return c;
    endfunction

endpackage

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int NUM_DW = 8,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_idx_i,
    input  logic [DW-1:0]                wr_data_i,
    output logic [NUM_DW-1:0][DW-1:0]    words_o
);

    for (genvar g = 0; g < NUM_DW; g++) begin : g_word
        logic [DW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en_i && (wr_idx_i == ADDR_W'(g))) begin
                word_d = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words_o[g] = word_q;
    end

endmodule

// File: rtl/mbox_owner_ctl.sv
module mbox_owner_ctl
    import mbox_pkg::*;
#(
    parameter int NUM_DW = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              owner_i,
    input  logic              rq_held_rst_i,
    input  logic              rq_wr_i,
    input  logic [ADDR_W-1:0] rq_idx_i,
    input  logic [DW-1:0]     rq_wdata_i,
    input  logic              rs_wr_i,
    input  logic [ADDR_W-1:0] rs_idx_i,
    input  logic [DW-1:0]     rs_wdata_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_idx_o,
    output logic [DW-1:0]     wr_data_o,
    output logic              to_rs_o,
    output logic              to_rq_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_DW - 1);

    typedef struct packed {
        logic err;
        logic to_rs;
        logic to_rq;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic              rq_live;
    logic              rq_take;
    logic              rs_take;
    logic [ADDR_W-1:0] pick_idx;
    logic [DW-1:0]     pick_data;

    always_comb begin
        // Requester traffic counts only when its function is alive.
        rq_live   = rq_wr_i && !rq_held_rst_i;
        // The owner bit admits exactly one side, so the two takes never overlap.
        rq_take   = rq_live && !owner_i;
        rs_take   = rs_wr_i && owner_i;

        pick_idx  = rq_take ? rq_idx_i   : rs_idx_i;
        pick_data = rq_take ? rq_wdata_i : rs_wdata_i;
        if (pick_idx == LAST_IDX) begin
            // Hardware decides the owner bit from the writer, not the data.
            pick_data = with_owner(pick_data, rq_take);
        end

        wr_en_o   = rq_take || rs_take;
        wr_idx_o  = pick_idx;
        wr_data_o = pick_data;

        st_d.err   = st_q.err || (rq_live && owner_i);
        st_d.to_rs = rq_take && (rq_idx_i == LAST_IDX);
        st_d.to_rq = rs_take && (rs_idx_i == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign to_rs_o = st_q.to_rs;
    assign to_rq_o = st_q.to_rq;
    assign err_o   = st_q.err;

endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
    import mbox_pkg::*;
#(
    parameter int NUM_DW = 8,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_i,
    input  logic [ADDR_W-1:0]         rd_idx_i,
    input  logic                      blank_i,
    input  logic [NUM_DW-1:0][DW-1:0] words_i,
    output logic [DW-1:0]             rdata_o
);

    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = blank_i ? '1 : words_i[rd_idx_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
    import mbox_pkg::*;
#(
    parameter  int NUM_DW = 8,
    localparam int ADDR_W = $clog2(NUM_DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_held_rst,
    input  logic              rq_wr,
    input  logic              rq_rd,
    input  logic [ADDR_W-1:0] rq_idx,
    input  logic [DW-1:0]     rq_wdata,
    output logic [DW-1:0]     rq_rdata,
    input  logic              rs_wr,
    input  logic              rs_rd,
    input  logic [ADDR_W-1:0] rs_idx,
    input  logic [DW-1:0]     rs_wdata,
    output logic [DW-1:0]     rs_rdata,
    output logic              hand_to_rs,
    output logic              hand_to_rq,
    output logic              rq_wr_err
);

    logic [NUM_DW-1:0][DW-1:0] words;
    logic                      wr_en;
    logic [ADDR_W-1:0]         wr_idx;
    logic [DW-1:0]             wr_data;
    logic                      owner;

    assign owner = words[NUM_DW-1][DW-1];

    mbox_store #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .words_o   (words)
    );

    mbox_owner_ctl #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) ctl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .owner_i       (owner),
        .rq_held_rst_i (rq_held_rst),
        .rq_wr_i       (rq_wr),
        .rq_idx_i      (rq_idx),
        .rq_wdata_i    (rq_wdata),
        .rs_wr_i       (rs_wr),
        .rs_idx_i      (rs_idx),
        .rs_wdata_i    (rs_wdata),
        .wr_en_o       (wr_en),
        .wr_idx_o      (wr_idx),
        .wr_data_o     (wr_data),
        .to_rs_o       (hand_to_rs),
        .to_rq_o       (hand_to_rq),
        .err_o         (rq_wr_err)
    );

    mbox_rd_port #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) rq_port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rq_rd),
        .rd_idx_i (rq_idx),
        .blank_i  (rq_held_rst),
        .words_i  (words),
        .rdata_o  (rq_rdata)
    );

    mbox_rd_port #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) rs_port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rs_rd),
        .rd_idx_i (rs_idx),
        .blank_i  (1'b0),
        .words_i  (words),
        .rdata_o  (rs_rdata)
    );

endmodule

// File: rtl/mbox_aperture_chk.sv
module mbox_aperture_chk #(
    parameter int NUM_DW = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rq_held_rst,
    input logic              rq_wr,
    input logic              rq_rd,
    input logic [ADDR_W-1:0] rq_idx,
    input logic              rs_wr,
    input logic [ADDR_W-1:0] rs_idx,
    input logic [31:0]       rq_rdata,
    input logic              hand_to_rs,
    input logic              hand_to_rq,
    input logic              rq_wr_err
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_DW - 1);

    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hand_to_rs |-> $past(rq_wr && !rq_held_rst && (rq_idx == LAST_IDX)));

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        hand_to_rs |=> !hand_to_rs);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hand_to_rq |-> $past(rs_wr && (rs_idx == LAST_IDX)));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rq_wr_err |=> rq_wr_err);

    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rq_wr_err) |-> $past(rq_wr && !rq_held_rst));

    a_r9_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_rd && rq_held_rst) |=> (rq_rdata == 32'hFFFF_FFFF));

    a_r9_no_err_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_held_rst && !rq_wr_err) |=> !rq_wr_err);

    a_r11_one_handover: assert property (@(posedge clk) disable iff (!rst_n)
        !(hand_to_rs && hand_to_rq));

endmodule

bind mbox_aperture mbox_aperture_chk #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rq_held_rst (rq_held_rst),
    .rq_wr       (rq_wr),
    .rq_rd       (rq_rd),
    .rq_idx      (rq_idx),
    .rs_wr       (rs_wr),
    .rs_idx      (rs_idx),
    .rq_rdata    (rq_rdata),
    .hand_to_rs  (hand_to_rs),
    .hand_to_rq  (hand_to_rq),
    .rq_wr_err   (rq_wr_err)
);

// File: tb/mbox_aperture_tb_top.sv
`timescale 1ns/1ps
module mbox_aperture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_held_rst = 1'b0;
    logic        rq_wr = 1'b0, rq_rd = 1'b0;
    logic [2:0]  rq_idx = '0;
    logic [31:0] rq_wdata = '0;
    logic [31:0] rq_rdata;
    logic        rs_wr = 1'b0, rs_rd = 1'b0;
    logic [2:0]  rs_idx = '0;
    logic [31:0] rs_wdata = '0;
    logic [31:0] rs_rdata;
    logic        hand_to_rs, hand_to_rq, rq_wr_err;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    mbox_aperture dut_i (
        .clk(clk), .rst_n(rst_n), .rq_held_rst(rq_held_rst),
        .rq_wr(rq_wr), .rq_rd(rq_rd), .rq_idx(rq_idx), .rq_wdata(rq_wdata), .rq_rdata(rq_rdata),
        .rs_wr(rs_wr), .rs_rd(rs_rd), .rs_idx(rs_idx), .rs_wdata(rs_wdata), .rs_rdata(rs_rdata),
        .hand_to_rs(hand_to_rs), .hand_to_rq(hand_to_rq), .rq_wr_err(rq_wr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: a plain array plus an owner flag.
    logic [31:0] mdl [8];
    bit          m_err, m_rs, m_rq, own;
    logic [31:0] m_rqd, m_rsd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mdl[i] = '0;
            m_err = 0; m_rs = 0; m_rq = 0; m_rqd = '0; m_rsd = '0;
        end else begin
            own  = mdl[7][31];
            m_rs = 0;
            m_rq = 0;
            if (rq_rd) m_rqd = rq_held_rst ? 32'hFFFF_FFFF : mdl[rq_idx];
            if (rs_rd) m_rsd = mdl[rs_idx];
            if (rq_wr && !rq_held_rst) begin
                if (own) m_err = 1;
                else begin
                    mdl[rq_idx] = rq_wdata;
                    if (rq_idx == 3'd7) begin mdl[7][31] = 1'b1; m_rs = 1; end
                end
            end
            if (rs_wr && own) begin
                mdl[rs_idx] = rs_wdata;
                if (rs_idx == 3'd7) begin mdl[7][31] = 1'b0; m_rq = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, rq_rdata, m_rqd);
            check(cur_req, rs_rdata, m_rsd);
            check(cur_req, {31'd0, hand_to_rs}, {31'd0, m_rs});
            check(cur_req, {31'd0, hand_to_rq}, {31'd0, m_rq});
            check(cur_req, {31'd0, rq_wr_err}, {31'd0, m_err});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rq_write(input int idx, input logic [31:0] d);
        rq_idx = idx[2:0]; rq_wdata = d; rq_wr = 1'b1;
        tick();
        rq_wr = 1'b0;
    endtask

    task automatic rs_write(input int idx, input logic [31:0] d);
        rs_idx = idx[2:0]; rs_wdata = d; rs_wr = 1'b1;
        tick();
        rs_wr = 1'b0;
    endtask

    task automatic rq_read(input int idx, output logic [31:0] d);
        rq_idx = idx[2:0]; rq_rd = 1'b1;
        tick();
        rq_rd = 1'b0;
        d = rq_rdata;
    endtask

    task automatic rs_read(input int idx, output logic [31:0] d);
        rs_idx = idx[2:0]; rs_rd = 1'b1;
        tick();
        rs_rd = 1'b0;
        d = rs_rdata;
    endtask

    task automatic both_write_last(input logic [31:0] rqd, input logic [31:0] rsd);
        rq_idx = 3'd7; rq_wdata = rqd; rq_wr = 1'b1;
        rs_idx = 3'd7; rs_wdata = rsd; rs_wr = 1'b1;
        tick();
        rq_wr = 1'b0; rs_wr = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5A5_0000 + 32'(i) * 32'h1111;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        cur_req = "R1";
        for (int i = 0; i < 8; i++) begin
            rq_read(i, d);
            check("R1", d, 32'h0);
        end
        check("R1", {31'd0, rq_wr_err}, 32'h0);
        check("R1", {30'd0, hand_to_rs, hand_to_rq}, 32'h0);

        // R2 payload writes and read-back
        cur_req = "R2";
        for (int i = 0; i < 7; i++) rq_write(i, pat(i));
        for (int i = 0; i < 7; i++) begin
            rq_read(i, d);
            check("R2", d, pat(i));
        end

        // R9 requester held in reset
        cur_req = "R9";
        rq_held_rst = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rq_read(i, d);
            check("R9", d, 32'hFFFF_FFFF);
        end
        rq_write(1, 32'h0000_DEAD);
        check("R9", {31'd0, rq_wr_err}, 32'h0);
        rs_read(1, d);
        check("R9", d, pat(1));
        rq_held_rst = 1'b0;
        rq_read(1, d);
        check("R9", d, pat(1));

        // R3 / R4 handover to the responder
        cur_req = "R4";
        rq_write(7, 32'h0000_0101);
        check("R4", {31'd0, hand_to_rs}, 32'h1);
        tick();
        check("R4", {31'd0, hand_to_rs}, 32'h0);
        cur_req = "R3";
        rq_read(7, d);
        check("R3", d, 32'h8000_0101);

        // R5 requester write refused while the responder owns the window
        cur_req = "R5";
        rq_write(2, 32'h0000_1234);
        check("R5", {31'd0, rq_wr_err}, 32'h1);
        rq_read(2, d);
        check("R5", d, pat(2));
        rs_read(2, d);
        check("R5", d, pat(2));

        // R6 / R7 / R10 responder reply
        cur_req = "R6";
        rs_read(0, d);
        check("R6", d, pat(0));
        rs_write(3, 32'h3333_CAFE);
        rs_read(3, d);
        check("R6", d, 32'h3333_CAFE);
        cur_req = "R7";
        rs_write(7, 32'h8100_0581);
        check("R7", {31'd0, hand_to_rq}, 32'h1);
        tick();
        check("R7", {31'd0, hand_to_rq}, 32'h0);
        cur_req = "R10";
        rq_read(7, d);
        check("R10", d, 32'h0100_0581);
        rq_read(3, d);
        check("R6", d, 32'h3333_CAFE);

        // R8 responder write while the requester owns the window
        cur_req = "R8";
        rs_write(4, 32'h0000_0BAD);
        rs_read(4, d);
        check("R8", d, pat(4));
        rs_write(7, 32'h0000_0082);
        check("R8", {31'd0, hand_to_rq}, 32'h0);
        rq_read(7, d);
        check("R8", d, 32'h0100_0581);

        // R11 same-cycle writes from both sides
        cur_req = "R11";
        both_write_last(32'hFFFF_0002, 32'h0000_0082);
        check("R11", {30'd0, hand_to_rs, hand_to_rq}, 32'h2);
        rq_read(7, d);
        check("R11", d, 32'hFFFF_0002);
        both_write_last(32'h0000_0001, 32'h8000_0282);
        check("R11", {30'd0, hand_to_rs, hand_to_rq}, 32'h1);
        rs_read(7, d);
        check("R11", d, 32'h0000_0282);

        // R5 sticky until reset, then R1 again
        cur_req = "R5";
        check("R5", {31'd0, rq_wr_err}, 32'h1);
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        cur_req = "R1";
        check("R1", {31'd0, rq_wr_err}, 32'h0);
        rq_read(7, d);
        check("R1", d, 32'h0);
        rq_read(0, d);
        check("R1", d, 32'h0);

        tick();
        finish_run();
    end

endmodule